// File: doc/BRIEF.md
# Multi-Destination Instruction Issue Unit

This unit sits between an instruction cache port and a memory highway. Each incoming word is a command plus a list of up to two targets. The unit drives the command onto the highway once for every target, one copy per clock cycle, starting with the first target. It keeps the command bits of each copy unchanged and changes only the target.

While a two-target instruction is still fanning out, the unit raises its own interlock so that no new word enters. That interlock is ORed with an interlock from the I/O side to form the pipeline-wide lock. When the I/O side claims the highway for a cycle, the pending copy waits in place. A command carrying the stop opcode sets a flag that stays set until reset.

Top module: `md_issue`

## Requirements
- R1: While reset is low, and right after it, issueValid, localLock, stopped and issueIdx are all 0, and inReady is 1 when extLock is 0. A later reset clears a set stopped flag.
- R2: An instruction accepted with 1 or 2 targets is issued that many times, on consecutive cycles when ioReq is low, starting the cycle after acceptance. Every copy carries the accepted command. Target k (k = 0 first) is taken from inDests[k*DEST_W +: DEST_W] and is issued as copy k+1.
- R3: issueIdx gives the 1-based number of the copy currently held (1 or 2), and 0 when nothing is held.
- R4: For a two-target instruction, localLock is 1 from the cycle after acceptance until the cycle in which the final copy is actually driven. It is 0 in that cycle, and it stays 1 while the final copy is deferred. A one-target instruction never raises localLock.
- R5: pipeLock equals localLock OR extLock.
- R6: inReady is 0 while extLock is 1, or while a held copy is not the final copy being driven this cycle. In the cycle the final copy is driven it is 1, so a new instruction can be taken back to back.
- R7: While ioReq is 1, issueValid is 0 and the held copy and its index are kept. The copy is driven once ioReq falls, with none lost or repeated.
- R8: An instruction with a target count of 0 completes its handshake, issues nothing and leaves localLock at 0.
- R9: A target count above MAX_DEST (count 3 with the defaults) is treated as MAX_DEST.
- R10: A command whose top OPC_W bits equal STOP_OPC (15 by default) sets stopped from the cycle after acceptance until reset. The instruction is still issued normally.
- R11: inValid while inReady is 0 has no effect: the held instruction continues and no extra copy appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word present |
| inReady | output | 1 | Unit takes the word at this edge |
| inCmd | input | CMD_W | Command field |
| inDestCnt | input | CNT_W | Number of targets (0..MAX_DEST, larger clamps) |
| inDests | input | MAX_DEST*DEST_W | Packed targets, first target in the low bits |
| extLock | input | 1 | Interlock raised by the I/O side |
| ioReq | input | 1 | I/O side owns the highway this cycle |
| issueValid | output | 1 | A copy is on the highway |
| issueCmd | output | CMD_W | Command of the current copy |
| issueDest | output | DEST_W | Target of the current copy |
| issueIdx | output | CNT_W | 1-based copy number, 0 when idle |
| localLock | output | 1 | This unit's interlock |
| pipeLock | output | 1 | Combined pipeline interlock |
| stopped | output | 1 | Sticky stop flag |

## Verification
The main function is tried with target counts of one, two, zero and an out-of-range three, and with data patterns that differ between the first and second target. This tells a correct first-then-second order from a swapped or repeated target, and tells clamping from dropping. Deferral is tried separately on the first copy and on the final copy; only the second case shows whether the lock is held through a deferred last copy. A second word presented during a fan-out, and again in the final-copy cycle, tells refused input from back-to-back acceptance.

// File: rtl/md_issue_pkg.sv
`timescale 1ns/1ps
package md_issue_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // load a new instruction into the holding registers
    logic drive;    // a copy is placed on the highway this cycle
  } issueStrobe_t;
endpackage

// File: rtl/md_issue_ctrl.sv
`timescale 1ns/1ps
module md_issue_ctrl
  import md_issue_pkg::*;
#(
  parameter int MAX_DEST = 2,
  parameter int CNT_W    = $clog2(MAX_DEST + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [CNT_W-1:0] inDestCnt,
  input  logic             isStop,
  input  logic             extLock,
  input  logic             ioReq,
  output logic             inReady,
  output logic             issueValid,
  output logic [CNT_W-1:0] issueIdx,
  output logic             localLock,
  output logic             pipeLock,
  output logic             stopped,
  output issueStrobe_t     strobe
);
  localparam logic [CNT_W-1:0] MaxCnt = CNT_W'(MAX_DEST);
  localparam logic [CNT_W-1:0] OneCnt = CNT_W'(1);

  logic             hold;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] effCnt;
  logic             lastCopy;
  logic             fire;
  logic             lastFire;
  logic             busy;
  logic             take;
  logic             stoppedQ;

  always_comb begin
    effCnt   = (inDestCnt > MaxCnt) ? MaxCnt : inDestCnt;
    lastCopy = hold && (idx == cnt);
    fire     = hold && !ioReq;
    lastFire = fire && lastCopy;
    busy     = hold && !lastFire;
    localLock = hold && (cnt > OneCnt) && !lastFire;
    pipeLock = localLock || extLock;
    inReady  = !localLock && !extLock && !busy;
    take     = inValid && inReady;
    issueValid = fire;
    issueIdx = hold ? idx : '0;
    stopped  = stoppedQ;
    strobe.capture = take;
    strobe.drive   = fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hold     <= 1'b0;
      idx      <= '0;
      cnt      <= '0;
      stoppedQ <= 1'b0;
    end else begin
      if (take && (effCnt != '0)) begin
        hold <= 1'b1;
        idx  <= OneCnt;
        cnt  <= effCnt;
      end else if (lastFire) begin
        hold <= 1'b0;
        idx  <= '0;
      end else if (fire) begin
        idx <= idx + OneCnt;
      end
      if (take && isStop) stoppedQ <= 1'b1;
    end
  end

  // R7
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hold && ioReq) |=> (hold && (idx == $past(idx))));

  // R4
  lock_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (take && (effCnt > OneCnt)) |=> localLock);

  // R2
  copy_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !lastCopy) |=> (issueIdx == $past(issueIdx) + OneCnt));

  // R10
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopped |=> stopped);

  // R8
  empty_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (take && (effCnt == '0) && !hold) |=> (!issueValid && !localLock));
endmodule

// File: rtl/md_issue_dp.sv
`timescale 1ns/1ps
module md_issue_dp
  import md_issue_pkg::*;
#(
  parameter int CMD_W    = 16,
  parameter int OPC_W    = 4,
  parameter int DEST_W   = 12,
  parameter int MAX_DEST = 2,
  parameter int CNT_W    = $clog2(MAX_DEST + 1),
  parameter int STOP_OPC = 15
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  issueStrobe_t               strobe,
  input  logic [CNT_W-1:0]           selIdx,
  input  logic [CMD_W-1:0]           inCmd,
  input  logic [MAX_DEST*DEST_W-1:0] inDests,
  output logic                       isStop,
  output logic [CMD_W-1:0]           issueCmd,
  output logic [DEST_W-1:0]          issueDest
);
  localparam logic [OPC_W-1:0] StopCode = OPC_W'(STOP_OPC);

  logic [CMD_W-1:0]  cmdQ;
  logic [DEST_W-1:0] destQ [MAX_DEST];

  always_ff @(posedge clk) begin
    if (!rstN)               cmdQ <= '0;
    else if (strobe.capture) cmdQ <= inCmd;
  end

  for (genvar k = 0; k < MAX_DEST; k++) begin : g_dest
    always_ff @(posedge clk) begin
      if (!rstN)               destQ[k] <= '0;
      else if (strobe.capture) destQ[k] <= inDests[k*DEST_W +: DEST_W];
    end
  end

  always_comb begin
    isStop    = (inCmd[CMD_W-1 -: OPC_W] == StopCode);
    issueCmd  = cmdQ;
    issueDest = '0;
    for (int k = 0; k < MAX_DEST; k++) begin
      if (selIdx == CNT_W'(k + 1)) issueDest = destQ[k];
    end
  end

  // R2
  cmd_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (issueCmd == $past(inCmd)));

  // R3
  sel_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drive |-> ((selIdx != '0) && (selIdx <= CNT_W'(MAX_DEST))));
endmodule

// File: rtl/md_issue.sv
`timescale 1ns/1ps
module md_issue
  import md_issue_pkg::*;
#(
  parameter int CMD_W    = 16,
  parameter int OPC_W    = 4,
  parameter int DEST_W   = 12,
  parameter int MAX_DEST = 2,
  parameter int STOP_OPC = 15,
  localparam int CNT_W   = $clog2(MAX_DEST + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [CMD_W-1:0]           inCmd,
  input  logic [CNT_W-1:0]           inDestCnt,
  input  logic [MAX_DEST*DEST_W-1:0] inDests,
  input  logic                       extLock,
  input  logic                       ioReq,
  output logic                       issueValid,
  output logic [CMD_W-1:0]           issueCmd,
  output logic [DEST_W-1:0]          issueDest,
  output logic [CNT_W-1:0]           issueIdx,
  output logic                       localLock,
  output logic                       pipeLock,
  output logic                       stopped
);
  issueStrobe_t strobe;
  logic         isStop;

  md_issue_ctrl #(.MAX_DEST(MAX_DEST), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDestCnt(inDestCnt),
    .isStop(isStop), .extLock(extLock), .ioReq(ioReq), .inReady(inReady),
    .issueValid(issueValid), .issueIdx(issueIdx), .localLock(localLock),
    .pipeLock(pipeLock), .stopped(stopped), .strobe(strobe)
  );

  md_issue_dp #(.CMD_W(CMD_W), .OPC_W(OPC_W), .DEST_W(DEST_W),
    .MAX_DEST(MAX_DEST), .CNT_W(CNT_W), .STOP_OPC(STOP_OPC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selIdx(issueIdx),
    .inCmd(inCmd), .inDests(inDests), .isStop(isStop),
    .issueCmd(issueCmd), .issueDest(issueDest)
  );
endmodule

// File: tb/md_issue_tb.sv
`timescale 1ns/1ps
module md_issue_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        inReady;
  logic [15:0] inCmd;
  logic [1:0]  inDestCnt;
  logic [23:0] inDests;
  logic        extLock;
  logic        ioReq;
  logic        issueValid;
  logic [15:0] issueCmd;
  logic [11:0] issueDest;
  logic [1:0]  issueIdx;
  logic        localLock;
  logic        pipeLock;
  logic        stopped;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  md_issue u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCmd(inCmd), .inDestCnt(inDestCnt), .inDests(inDests),
    .extLock(extLock), .ioReq(ioReq), .issueValid(issueValid),
    .issueCmd(issueCmd), .issueDest(issueDest), .issueIdx(issueIdx),
    .localLock(localLock), .pipeLock(pipeLock), .stopped(stopped)
  );

  // {command, target count, first target, second target}
  localparam logic [41:0] VEC [6] = '{
    {16'h1234, 2'd1, 12'h0A1, 12'h0B2},
    {16'h2345, 2'd2, 12'h111, 12'h222},
    {16'h3456, 2'd0, 12'h333, 12'h444},
    {16'h4567, 2'd3, 12'h555, 12'h666},
    {16'h5A5A, 2'd2, 12'hFFF, 12'h000},
    {16'h0001, 2'd1, 12'h800, 12'h001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic present(input logic [15:0] c, input logic [1:0] n,
                         input logic [11:0] d0, input logic [11:0] d1);
    inValid = 1'b1; inCmd = c; inDestCnt = n; inDests = {d1, d0};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inCmd = '0; inDestCnt = '0; inDests = '0;
    extLock = 1'b0; ioReq = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 issueValid", issueValid, 0);
    chk("R1 localLock", localLock, 0);
    chk("R1 stopped", stopped, 0);
    chk("R1 issueIdx", issueIdx, 0);
    chk("R1 inReady", inReady, 1);
    @(negedge clk); rstN = 1'b1;

    // table walk: no deferral, no external lock
    for (int v = 0; v < 6; v++) begin
      logic [15:0] c;
      logic [1:0]  n;
      logic [11:0] d0;
      logic [11:0] d1;
      int          e;
      c = VEC[v][41:26]; n = VEC[v][25:24]; d0 = VEC[v][23:12]; d1 = VEC[v][11:0];
      e = (n > 2'd2) ? 2 : int'(n);
      @(negedge clk); present(c, n, d0, d1); #1;
      chk("R6 ready idle", inReady, 1);
      @(negedge clk); inValid = 1'b0; #1;
      if (e == 0) begin
        chk("R8 no issue", issueValid, 0);
        chk("R8 no lock", localLock, 0);
        chk("R3 idle idx", issueIdx, 0);
      end else begin
        for (int k = 1; k <= e; k++) begin
          if (k > 1) begin @(negedge clk); #1; end
          chk(n == 2'd3 ? "R9 clamp valid" : "R2 valid", issueValid, 1);
          chk("R2 cmd", issueCmd, c);
          chk("R2 dest", issueDest, (k == 1) ? d0 : d1);
          chk("R3 idx", issueIdx, k);
          chk("R4 lock", localLock, (e == 2 && k == 1));
          chk("R5 pipeLock", pipeLock, (e == 2 && k == 1));
        end
      end
      @(negedge clk); #1;
      chk(n == 2'd3 ? "R9 no third copy" : "R2 idle after", issueValid, 0);
      chk("R3 idx idle", issueIdx, 0);
    end

    // R7: deferral on the first and on the final copy
    @(negedge clk); present(16'h6000, 2'd2, 12'h0C1, 12'h0C2);
    @(negedge clk); inValid = 1'b0; ioReq = 1'b1; #1;
    chk("R7 deferred", issueValid, 0);
    chk("R7 idx kept", issueIdx, 1);
    chk("R4 lock deferred", localLock, 1);
    chk("R6 not ready", inReady, 0);
    @(negedge clk); ioReq = 1'b0; #1;
    chk("R7 first after", issueValid, 1);
    chk("R7 first dest", issueDest, 12'h0C1);
    @(negedge clk); ioReq = 1'b1; #1;
    chk("R7 final deferred", issueValid, 0);
    chk("R7 final idx", issueIdx, 2);
    chk("R4 lock held on final", localLock, 1);
    chk("R6 not ready final", inReady, 0);
    @(negedge clk); ioReq = 1'b0; #1;
    chk("R7 final driven", issueValid, 1);
    chk("R7 final dest", issueDest, 12'h0C2);
    chk("R4 lock dropped", localLock, 0);
    @(negedge clk); #1;
    chk("R7 no repeat", issueValid, 0);

    // R11 and R6: second word during a fan-out, then back to back
    @(negedge clk); present(16'h7001, 2'd2, 12'h0D1, 12'h0D2);
    @(negedge clk); present(16'h7002, 2'd1, 12'h0E1, 12'h0E2); #1;
    chk("R6 refused mid", inReady, 0);
    chk("R11 first copy", issueDest, 12'h0D1);
    @(negedge clk); #1;
    chk("R11 cmd kept", issueCmd, 16'h7001);
    chk("R11 second dest", issueDest, 12'h0D2);
    chk("R6 ready final cycle", inReady, 1);
    @(negedge clk); inValid = 1'b0; #1;
    chk("R6 back to back valid", issueValid, 1);
    chk("R6 back to back cmd", issueCmd, 16'h7002);
    chk("R6 back to back dest", issueDest, 12'h0E1);
    chk("R4 single no lock", localLock, 0);
    @(negedge clk); #1;
    chk("R2 idle", issueValid, 0);

    // R5 and R11: external lock
    @(negedge clk); extLock = 1'b1; present(16'h7003, 2'd1, 12'h0AA, 12'h0BB); #1;
    chk("R6 ext not ready", inReady, 0);
    chk("R5 ext pipeLock", pipeLock, 1);
    chk("R5 ext local", localLock, 0);
    @(negedge clk); extLock = 1'b0; inValid = 1'b0; #1;
    chk("R11 not taken", issueValid, 0);

    // R10: stop
    @(negedge clk); present(16'hF00D, 2'd1, 12'h0F1, 12'h0F2); #1;
    chk("R10 before", stopped, 0);
    @(negedge clk); inValid = 1'b0; #1;
    chk("R10 set", stopped, 1);
    chk("R10 issued", issueValid, 1);
    chk("R10 cmd", issueCmd, 16'hF00D);
    @(negedge clk); #1; @(negedge clk); #1;
    chk("R10 sticky", stopped, 1);

    // R1: reset clears stop
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); #1;
    chk("R1 stop cleared", stopped, 0);
    @(negedge clk); rstN = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule